// File: doc/BRIEF.md
# Addressing-Mode Effective Address Generator

This block sits in the fetch and decode path of an 8-bit microcontroller. It takes instruction bytes one at a time from a byte-wide stream. With the first byte of each instruction it also takes the address of that instruction. It takes the X and Y index register values and a branch-condition flag as well. For each instruction it classifies the addressing mode and collects the operand bytes. It then produces either an immediate data byte or a 16-bit effective address, together with the instruction length and the address execution continues from.

Bytes are offered with a valid flag and may arrive with idle cycles between them. One cycle after the last byte of an instruction is accepted, the block raises a one-cycle completion strobe. The mode, address, data, length and next-address outputs stay stable until the next completion.

Only a representative subset of opcodes is classified, by the upper nibble of the opcode. Three prebyte values are recognised, and each adds one byte to the instruction that follows it. The ALU, the register file and the memory accesses themselves are outside this block.

Top module: `ea_gen`

## Requirements
- R1: After reset `done` is 0 and `mode`, `effAddr`, `immData`, `instrLen` and `nextPc` are all 0.
- R2: An opcode whose upper nibble is 8 or C (for example $86, load A immediate) is immediate mode (mode code 1). It takes one data byte, `immData` equals that byte, `effAddr` is 0 and the length is 2.
- R3: An opcode whose upper nibble is 9 or D is direct mode (code 2). It takes one address byte b, `effAddr` = {8'h00, b} and the length is 2.
- R4: An opcode whose upper nibble is 7, B or F is extended mode (code 3). It takes two address bytes, the first being the high byte, `effAddr` = {first, second} and the length is 3.
- R5: An opcode whose upper nibble is 6, A or E is indexed mode. Without the $18 prebyte it is code 4, and `effAddr` = X + zero-extended offset byte, modulo 2^16. The length is 2.
- R6: Behind the $18 prebyte, an indexed opcode uses Y in place of X and reports mode code 5. The length is 3.
- R7: The bytes $18, $1A and $CD are prebytes when they start an instruction. Each adds one to the length. An extended opcode behind a prebyte is 4 bytes long, and an inherent opcode behind a prebyte is 2 bytes long.
- R8: Any other opcode whose upper nibble is 0, 1, 3, 4 or 5 is inherent (code 0). It has no operand bytes, the length is 1 and `effAddr` and `immData` are 0.
- R9: An opcode with upper nibble 2 is relative mode (code 6) and is 2 bytes long. `effAddr` is the branch target: the address after the instruction plus the sign-extended offset byte, modulo 2^16.
- R10: `nextPc` is the branch target when `branchCond`, sampled with the offset byte, is 1. Otherwise, and for every non-branch instruction, `nextPc` is the instruction address plus its length.
- R11: `done` is 1 in exactly the cycle after the last byte of an instruction is accepted, and 0 otherwise. While `byteValid` is 0 no byte is consumed. The outputs hold until the next completion.
- R12: `pcIn` is sampled only with the first byte of an instruction. Values it has during later bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A byte is offered on byteIn this cycle |
| byteIn | input | 8 | Instruction stream byte |
| pcIn | input | 16 | Address of the instruction's first byte, sampled with that byte |
| xIn | input | 16 | X index register value |
| yIn | input | 16 | Y index register value |
| branchCond | input | 1 | Branch condition, sampled with the offset byte |
| done | output | 1 | One-cycle completion strobe |
| mode | output | 3 | Addressing mode code |
| effAddr | output | 16 | Effective address or branch target |
| immData | output | 8 | Immediate data byte |
| instrLen | output | 3 | Instruction length in bytes |
| nextPc | output | 16 | Address execution continues from |

## Verification
The bench builds the block with its default parameters: a 16-bit address and $18, $1A and $CD as the prebyte codes. At that width, index and branch sums that cross $FFFF wrap back to low memory, and branch offsets of -128 and +127 reach their extremes. Because $18 is the Y-select code, both index registers can be exercised, and the other two prebytes show the length stretch without a change of register. Idle cycles between bytes and a `pcIn` that changes after the first byte test the stall and sampling rules.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  typedef enum logic [2:0] {
    MODE_INH   = 3'd0,
    MODE_IMM   = 3'd1,
    MODE_DIR   = 3'd2,
    MODE_EXT   = 3'd3,
    MODE_IDX_X = 3'd4,
    MODE_IDX_Y = 3'd5,
    MODE_REL   = 3'd6
  } addrMode_e;

  // Strobes issued by the control to the datapath for the byte on byteIn
  typedef struct packed {
    logic startInstr;  // first byte of an instruction
    logic takePre;     // byte is a prebyte
    logic takeOpc;     // byte is the opcode
    logic takeOp1;     // byte is a non-final operand byte
    logic finish;      // byte is the last one of the instruction
  } eaStrobes_t;

  // Mode class from the upper nibble of the opcode
  function automatic addrMode_e decodeMode(input logic [7:0] opc);
    addrMode_e m;
    unique case (opc[7:4])
      4'h8, 4'hC:       m = MODE_IMM;
      4'h9, 4'hD:       m = MODE_DIR;
      4'h7, 4'hB, 4'hF: m = MODE_EXT;
      4'h6, 4'hA, 4'hE: m = MODE_IDX_X;
      4'h2:             m = MODE_REL;
      default:          m = MODE_INH;
    endcase
    return m;
  endfunction

  // Operand bytes following the opcode
  function automatic logic [1:0] operandCount(input addrMode_e m);
    logic [1:0] n;
    unique case (m)
      MODE_INH: n = 2'd0;
      MODE_EXT: n = 2'd2;
      default:  n = 2'd1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ea_gen_ctrl.sv
module ea_gen_ctrl
  import ea_gen_pkg::*;
#(
  parameter logic [7:0] PRE_Y = 8'h18,
  parameter logic [7:0] PRE_A = 8'h1A,
  parameter logic [7:0] PRE_B = 8'hCD
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  output eaStrobes_t strobes,
  output logic       doneOut
);

  typedef enum logic [1:0] {ST_FIRST, ST_OPC, ST_OPND} ctrlState_e;

  ctrlState_e state, nextState;
  logic [1:0] remaining, nextRemaining;
  logic       isPre;
  logic [1:0] newCount;

  always_comb begin
    isPre    = (byteIn == PRE_Y) || (byteIn == PRE_A) || (byteIn == PRE_B);
    newCount = operandCount(decodeMode(byteIn));
  end

  always_comb begin
    strobes       = '0;
    nextState     = state;
    nextRemaining = remaining;
    unique case (state)
      ST_FIRST: begin
        if (byteValid) begin
          strobes.startInstr = 1'b1;
          if (isPre) begin
            strobes.takePre = 1'b1;
            nextState       = ST_OPC;
          end else begin
            strobes.takeOpc = 1'b1;
            if (newCount == 2'd0) begin
              strobes.finish = 1'b1;
            end else begin
              nextState     = ST_OPND;
              nextRemaining = newCount;
            end
          end
        end
      end
      ST_OPC: begin
        if (byteValid) begin
          strobes.takeOpc = 1'b1;
          if (newCount == 2'd0) begin
            strobes.finish = 1'b1;
            nextState      = ST_FIRST;
          end else begin
            nextState     = ST_OPND;
            nextRemaining = newCount;
          end
        end
      end
      ST_OPND: begin
        if (byteValid) begin
          if (remaining == 2'd1) begin
            strobes.finish = 1'b1;
            nextState      = ST_FIRST;
          end else begin
            strobes.takeOp1 = 1'b1;
            nextRemaining   = remaining - 2'd1;
          end
        end
      end
      default: nextState = ST_FIRST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_FIRST;
      remaining <= 2'd0;
      doneOut   <= 1'b0;
    end else begin
      state     <= nextState;
      remaining <= nextRemaining;
      doneOut   <= strobes.finish;
    end
  end

endmodule

// File: rtl/ea_gen_datapath.sv
module ea_gen_datapath
  import ea_gen_pkg::*;
#(
  parameter int         ADDR_W = 16,
  parameter logic [7:0] PRE_Y  = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  eaStrobes_t        strobes,
  input  logic [7:0]        byteIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] xIn,
  input  logic [ADDR_W-1:0] yIn,
  input  logic              branchCond,
  output logic [2:0]        modeOut,
  output logic [ADDR_W-1:0] effAddrOut,
  output logic [7:0]        immOut,
  output logic [2:0]        lenOut,
  output logic [ADDR_W-1:0] nextPcOut
);

  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] pcQ;
  logic              preQ, ySelQ;
  addrMode_e         modeQ;
  logic [7:0]        op1Q;

  logic [ADDR_W-1:0] pcNow, fallThru, relOff, relTarget, idxBase;
  logic              preNow, ySelNow;
  addrMode_e         baseMode, modeNow;
  logic [2:0]        lenNow;
  logic [ADDR_W-1:0] eaNow, npcNow;
  logic [7:0]        immNow;

  always_comb begin
    pcNow    = strobes.startInstr ? pcIn : pcQ;
    preNow   = strobes.startInstr ? strobes.takePre : preQ;
    ySelNow  = strobes.startInstr ? (strobes.takePre && byteIn == PRE_Y) : ySelQ;
    baseMode = strobes.takeOpc ? decodeMode(byteIn) : modeQ;
    modeNow  = (baseMode == MODE_IDX_X && ySelNow) ? MODE_IDX_Y : baseMode;
    lenNow   = 3'd1 + {1'b0, operandCount(baseMode)} + {2'b00, preNow};
    fallThru = pcNow + ADDR_W'(lenNow);
    relOff   = {{HI_W{byteIn[7]}}, byteIn};
    relTarget = fallThru + relOff;
    idxBase  = (modeNow == MODE_IDX_Y) ? yIn : xIn;

    eaNow  = '0;
    immNow = 8'h00;
    npcNow = fallThru;
    unique case (modeNow)
      MODE_IMM:               immNow = byteIn;
      MODE_DIR:               eaNow  = {{HI_W{1'b0}}, byteIn};
      MODE_EXT:               eaNow  = ADDR_W'({op1Q, byteIn});
      MODE_IDX_X, MODE_IDX_Y: eaNow  = idxBase + ADDR_W'(byteIn);
      MODE_REL: begin
        eaNow = relTarget;
        if (branchCond) npcNow = relTarget;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ        <= '0;
      preQ       <= 1'b0;
      ySelQ      <= 1'b0;
      modeQ      <= MODE_INH;
      op1Q       <= 8'h00;
      modeOut    <= 3'd0;
      effAddrOut <= '0;
      immOut     <= 8'h00;
      lenOut     <= 3'd0;
      nextPcOut  <= '0;
    end else begin
      if (strobes.startInstr) begin
        pcQ   <= pcIn;
        preQ  <= strobes.takePre;
        ySelQ <= strobes.takePre && (byteIn == PRE_Y);
      end
      if (strobes.takeOpc) modeQ <= decodeMode(byteIn);
      if (strobes.takeOp1) op1Q  <= byteIn;
      if (strobes.finish) begin
        modeOut    <= modeNow;
        effAddrOut <= eaNow;
        immOut     <= immNow;
        lenOut     <= lenNow;
        nextPcOut  <= npcNow;
      end
    end
  end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int         ADDR_W = 16,
  parameter logic [7:0] PRE_Y  = 8'h18,
  parameter logic [7:0] PRE_A  = 8'h1A,
  parameter logic [7:0] PRE_B  = 8'hCD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] xIn,
  input  logic [ADDR_W-1:0] yIn,
  input  logic              branchCond,
  output logic              done,
  output logic [2:0]        mode,
  output logic [ADDR_W-1:0] effAddr,
  output logic [7:0]        immData,
  output logic [2:0]        instrLen,
  output logic [ADDR_W-1:0] nextPc
);

  eaStrobes_t strobes;

  ea_gen_ctrl #(.PRE_Y(PRE_Y), .PRE_A(PRE_A), .PRE_B(PRE_B)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .byteIn    (byteIn),
    .strobes   (strobes),
    .doneOut   (done)
  );

  ea_gen_datapath #(.ADDR_W(ADDR_W), .PRE_Y(PRE_Y)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .byteIn     (byteIn),
    .pcIn       (pcIn),
    .xIn        (xIn),
    .yIn        (yIn),
    .branchCond (branchCond),
    .modeOut    (mode),
    .effAddrOut (effAddr),
    .immOut     (immData),
    .lenOut     (instrLen),
    .nextPcOut  (nextPc)
  );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteValid,
  input logic              done,
  input logic [2:0]        mode,
  input logic [ADDR_W-1:0] effAddr,
  input logic [7:0]        immData,
  input logic [2:0]        instrLen
);

  // R3
  direct_high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && mode == 3'd2) |-> (effAddr[ADDR_W-1:8] == '0));

  // R8
  inherent_no_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && mode == 3'd0) |-> (effAddr == '0 && immData == 8'h00 && instrLen <= 3'd2));

  // R2
  immediate_no_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && mode == 3'd1) |-> (effAddr == '0));

  // R7
  extended_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && mode == 3'd3) |-> (instrLen == 3'd3 || instrLen == 3'd4));

  // R9
  relative_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && mode == 3'd6) |-> (instrLen >= 3'd2));

  // R11
  done_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(byteValid));

endmodule

bind ea_gen ea_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .byteValid (byteValid),
  .done      (done),
  .mode      (mode),
  .effAddr   (effAddr),
  .immData   (immData),
  .instrLen  (instrLen)
);

// File: tb/ea_gen_tb.sv
module ea_gen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = 8'h00;
  logic [15:0] pcIn = 16'h0000;
  logic [15:0] xIn = 16'h0000;
  logic [15:0] yIn = 16'h0000;
  logic        branchCond = 1'b0;
  logic        done;
  logic [2:0]  mode;
  logic [15:0] effAddr;
  logic [7:0]  immData;
  logic [2:0]  instrLen;
  logic [15:0] nextPc;

  int checks = 0;
  int errs = 0;

  always #10 clk = ~clk;  // 50 MHz

  ea_gen u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .pcIn(pcIn), .xIn(xIn), .yIn(yIn), .branchCond(branchCond),
    .done(done), .mode(mode), .effAddr(effAddr), .immData(immData),
    .instrLen(instrLen), .nextPc(nextPc)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Offer n bytes (first byte in bs[31:24]); gap idle cycles between bytes.
  // pcIn and branchCond carry wrong values except on the byte that samples them.
  task automatic issue(input int n, input logic [31:0] bs, input logic [15:0] pc,
                       input logic cond, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid  = 1'b1;
      byteIn     = bs[31-8*i -: 8];
      pcIn       = (i == 0) ? pc : ~pc;
      branchCond = (i == n-1) ? cond : ~cond;
      if (i != n-1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          byteValid = 1'b0;
          byteIn    = 8'h4C;
          chk("R11 no done during stall", {15'd0, done}, 16'd1 - 16'd1);
        end
      end
    end
    @(negedge clk);
    byteValid = 1'b0;
    byteIn    = 8'h00;
    pcIn      = 16'hDEAD;
  endtask

  task automatic expectOut(input string tag, input logic [2:0] m, input logic [15:0] ea,
                           input logic [7:0] imm, input logic [2:0] len, input logic [15:0] npc);
    chk({tag, " done"}, {15'd0, done}, 16'd1);
    chk({tag, " mode"}, {13'd0, mode}, {13'd0, m});
    chk({tag, " effAddr"}, effAddr, ea);
    chk({tag, " immData"}, {8'd0, immData}, {8'd0, imm});
    chk({tag, " instrLen"}, {13'd0, instrLen}, {13'd0, len});
    chk({tag, " nextPc"}, nextPc, npc);
  endtask

  function automatic logic [15:0] relTgt(input logic [15:0] pc, input logic [7:0] off);
    return pc + 16'd2 + {{8{off[7]}}, off};
  endfunction

  task automatic testReset();
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 mode", {13'd0, mode}, 16'd0);
    chk("R1 effAddr", effAddr, 16'd0);
    chk("R1 immData", {8'd0, immData}, 16'd0);
    chk("R1 instrLen", {13'd0, instrLen}, 16'd0);
    chk("R1 nextPc", nextPc, 16'd0);
  endtask

  task automatic testImmediate();
    issue(2, 32'h860F_0000, 16'h1000, 1'b0, 0);
    expectOut("R2 imm $86", 3'd1, 16'h0000, 8'h0F, 3'd2, 16'h1002);
    issue(2, 32'hC6A5_0000, 16'h3FFE, 1'b1, 0);
    expectOut("R2 imm $C6", 3'd1, 16'h0000, 8'hA5, 3'd2, 16'h4000);
  endtask

  task automatic testDirect();
    issue(2, 32'h967F_0000, 16'h0100, 1'b0, 0);
    expectOut("R3 dir $96", 3'd2, 16'h007F, 8'h00, 3'd2, 16'h0102);
    issue(2, 32'hD6FF_0000, 16'h0200, 1'b0, 0);
    expectOut("R3 dir $D6", 3'd2, 16'h00FF, 8'h00, 3'd2, 16'h0202);
  endtask

  task automatic testExtended();
    issue(3, 32'hB612_3400, 16'h2000, 1'b0, 0);
    expectOut("R4 R12 ext $B6", 3'd3, 16'h1234, 8'h00, 3'd3, 16'h2003);
    issue(3, 32'h7FFE_DC00, 16'hFFFE, 1'b0, 0);
    expectOut("R4 ext $7F wrap", 3'd3, 16'hFEDC, 8'h00, 3'd3, 16'h0001);
  endtask

  task automatic testIndexed();
    xIn = 16'hFFF8; yIn = 16'h9999;
    issue(2, 32'hA610_0000, 16'h0400, 1'b0, 0);
    expectOut("R5 idx X wrap", 3'd4, 16'h0008, 8'h00, 3'd2, 16'h0402);
    xIn = 16'h1234;
    issue(2, 32'hE6FF_0000, 16'h0500, 1'b0, 0);
    expectOut("R5 idx X off $FF", 3'd4, 16'h1333, 8'h00, 3'd2, 16'h0502);
    xIn = 16'h1111; yIn = 16'h4000;
    issue(3, 32'h18A6_0500, 16'h0600, 1'b0, 0);
    expectOut("R6 idx Y", 3'd5, 16'h4005, 8'h00, 3'd3, 16'h0603);
    yIn = 16'hFFFF;
    issue(3, 32'h1866_0100, 16'h0700, 1'b0, 0);
    expectOut("R6 idx Y wrap", 3'd5, 16'h0000, 8'h00, 3'd3, 16'h0703);
  endtask

  task automatic testPrebyte();
    issue(4, 32'h1AB3_ABCD, 16'h0800, 1'b0, 0);
    expectOut("R7 $1A ext", 3'd3, 16'hABCD, 8'h00, 3'd4, 16'h0804);
    xIn = 16'h2000; yIn = 16'h5000;
    issue(3, 32'hCDA6_1000, 16'h0900, 1'b0, 0);
    expectOut("R7 $CD idx X", 3'd4, 16'h2010, 8'h00, 3'd3, 16'h0903);
    issue(2, 32'h1808_0000, 16'h0A00, 1'b0, 0);
    expectOut("R7 $18 inh", 3'd0, 16'h0000, 8'h00, 3'd2, 16'h0A02);
  endtask

  task automatic testInherent();
    issue(1, 32'h4C00_0000, 16'h0B00, 1'b1, 0);
    expectOut("R8 inh $4C", 3'd0, 16'h0000, 8'h00, 3'd1, 16'h0B01);
    issue(1, 32'h1B00_0000, 16'hFFFF, 1'b0, 0);
    expectOut("R8 inh $1B wrap", 3'd0, 16'h0000, 8'h00, 3'd1, 16'h0000);
  endtask

  task automatic testBranch();
    issue(2, 32'h207F_0000, 16'h1000, 1'b1, 0);
    expectOut("R9 R10 +127 taken", 3'd6, relTgt(16'h1000, 8'h7F), 8'h00, 3'd2,
              relTgt(16'h1000, 8'h7F));
    issue(2, 32'h2680_0000, 16'h1000, 1'b1, 0);
    expectOut("R9 R10 -128 taken", 3'd6, relTgt(16'h1000, 8'h80), 8'h00, 3'd2,
              relTgt(16'h1000, 8'h80));
    issue(2, 32'h2410_0000, 16'h1000, 1'b0, 0);
    expectOut("R10 not taken", 3'd6, relTgt(16'h1000, 8'h10), 8'h00, 3'd2, 16'h1002);
    issue(2, 32'h227F_0000, 16'hFFF0, 1'b1, 0);
    expectOut("R9 wrap fwd", 3'd6, relTgt(16'hFFF0, 8'h7F), 8'h00, 3'd2,
              relTgt(16'hFFF0, 8'h7F));
    issue(2, 32'h2780_0000, 16'h0010, 1'b1, 0);
    expectOut("R9 wrap back", 3'd6, relTgt(16'h0010, 8'h80), 8'h00, 3'd2,
              relTgt(16'h0010, 8'h80));
  endtask

  task automatic testStall();
    issue(3, 32'hF6BE_EF00, 16'h3000, 1'b0, 3);
    expectOut("R11 R12 stalled ext", 3'd3, 16'hBEEF, 8'h00, 3'd3, 16'h3003);
    @(negedge clk);
    chk("R11 done one cycle", {15'd0, done}, 16'd0);
    chk("R11 effAddr held", effAddr, 16'hBEEF);
    chk("R11 nextPc held", nextPc, 16'h3003);
  endtask

  initial begin
    #(200000 * 20);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testImmediate();
    testDirect();
    testExtended();
    testIndexed();
    testPrebyte();
    testInherent();
    testBranch();
    testStall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

endmodule